// File: doc/BRIEF.md
# Delayed Branch Target Unit

This unit decides where the program counter goes for a RISC pipeline with one architectural delay slot. Each cycle with an issued instruction, it receives the instruction's PC, its control-transfer kind, a signed 26-bit word displacement, a register-sourced target and the compare flag. A control transfer that is taken does not redirect at once. The unit first computes the destination and holds it. It then waits for exactly one more issued instruction, which is the delay slot. Only after that instruction does it raise a redirect to the held destination. Linking transfers also emit a write of PC+8 to link register 9, so a return skips the delay slot.

The return-from-exception kind has no delay slot. It redirects straight to the saved exception PC and writes the saved status word back into the status register. A control-transfer instruction that arrives in a delay slot is reported as illegal. It changes nothing, and the pending redirect still completes.

The control is a two-state machine. `ST_IDLE` waits for a taken transfer and moves to `ST_SLOT` when one issues. `ST_SLOT` holds the destination and returns to `ST_IDLE` when the delay-slot instruction issues, which fires the redirect. Reset returns the machine to `ST_IDLE`. Cycles in which no instruction issues never change the state.

Top module: `dbt_unit`

## Requirements
- R1: After reset the unit is in `ST_IDLE`: `slot_pending_o`, `redirect_o`, `link_we_o`, `sr_we_o` and `illegal_o` are all 0, and `target_o` is 0.
- R2: For relative kinds (J=1, JAL=2, BF=5, BNF=6) the destination is `pc_i + (sign-extended disp_i << 2)`, taken modulo 2^32. It appears on `target_o` one cycle after issue.
- R3: BF (5) is taken only when `flag_i`=1, and BNF (6) only when `flag_i`=0. A branch that is not taken leaves the unit in `ST_IDLE` with no redirect and no slot.
- R4: JR (3) and JALR (4) use `reg_tgt_i` unchanged as the destination.
- R5: JAL (2) and JALR (4) pulse `link_we_o` for one cycle, the cycle after issue, with `link_val_o` = `pc_i`+8 (mod 2^32) and `link_idx_o` = 9.
- R6: After a taken transfer, `slot_pending_o` stays high and `target_o` stays stable until the next issued instruction; idle cycles (`valid_i`=0) do not end the wait. One cycle after that delay-slot instruction issues, `redirect_o` pulses once with `redirect_pc_o` = the held destination, and the unit returns to `ST_IDLE`.
- R7: RFE (7) issued in `ST_IDLE` pulses `redirect_o` one cycle later with `redirect_pc_o` = `epc_i`, and in the same cycle pulses `sr_we_o` with `sr_val_o` = `esr_i`. It opens no delay slot.
- R8: Any kind other than NONE (0) issued in `ST_SLOT` pulses `illegal_o` with the redirect. It produces no link write, no status write and no new slot.
- R9: With `valid_i`=0, or with kind NONE (0) in `ST_IDLE`, the outputs show no strobe and the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | An instruction issues this cycle |
| kind_i | input | 3 | Transfer kind: 0 NONE, 1 J, 2 JAL, 3 JR, 4 JALR, 5 BF, 6 BNF, 7 RFE |
| pc_i | input | 32 | PC of the issuing instruction |
| disp_i | input | 26 | Signed word displacement |
| reg_tgt_i | input | 32 | Register-sourced destination |
| flag_i | input | 1 | Compare flag |
| epc_i | input | 32 | Saved exception PC |
| esr_i | input | 32 | Saved status word |
| slot_pending_o | output | 1 | A taken transfer waits for its delay slot |
| target_o | output | 32 | Held delayed destination |
| redirect_o | output | 1 | Redirect the fetch PC this cycle |
| redirect_pc_o | output | 32 | Redirect destination |
| link_we_o | output | 1 | Link register write strobe |
| link_idx_o | output | 5 | Link register index |
| link_val_o | output | 32 | Link value (PC+8) |
| sr_we_o | output | 1 | Status register restore strobe |
| sr_val_o | output | 32 | Restored status word |
| illegal_o | output | 1 | Control transfer found in a delay slot |

## Verification
The bench builds the unit with its default parameters: 32-bit PCs, a 26-bit displacement and link index 9. At these widths the displacement sign bit sits well below the PC width, so both negative displacements and wrap-around at the top of the address space can be reached. Those two cases exercise the sign extension and the modulo arithmetic of both the destination and the link value. The same width lets the stimulus cover every transfer kind, both flag polarities, idle gaps inside a delay slot, and both a branch and an RFE placed in a slot.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
    typedef enum logic [2:0] {
        XK_NONE = 3'd0,
        XK_J    = 3'd1,
        XK_JAL  = 3'd2,
        XK_JR   = 3'd3,
        XK_JALR = 3'd4,
        XK_BF   = 3'd5,
        XK_BNF  = 3'd6,
        XK_RFE  = 3'd7
    } xfer_kind_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SLOT = 1'b1
    } slot_state_e;
endpackage

// File: rtl/dbt_decode.sv
module dbt_decode
    import dbt_pkg::*;
(
    input  xfer_kind_e kind_i,
    input  logic       flag_i,
    output logic       taken_o,
    output logic       is_ctrl_o,
    output logic       links_o,
    output logic       use_reg_o,
    output logic       is_rfe_o
);
    always_comb begin
        taken_o   = 1'b0;
        links_o   = 1'b0;
        use_reg_o = 1'b0;
        is_rfe_o  = 1'b0;
        unique case (kind_i)
            XK_NONE: ;
            XK_J:    taken_o = 1'b1;
            XK_JAL:  begin taken_o = 1'b1; links_o = 1'b1; end
            XK_JR:   begin taken_o = 1'b1; use_reg_o = 1'b1; end
            XK_JALR: begin taken_o = 1'b1; use_reg_o = 1'b1; links_o = 1'b1; end
            XK_BF:   taken_o = flag_i;
            XK_BNF:  taken_o = !flag_i;
            XK_RFE:  is_rfe_o = 1'b1;
            default: ;
        endcase
        is_ctrl_o = (kind_i != XK_NONE);
    end
endmodule

// File: rtl/dbt_target.sv
module dbt_target #(
    parameter int XLEN  = 32,
    parameter int DISPW = 26
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [DISPW-1:0] disp_i,
    input  logic [XLEN-1:0]  reg_tgt_i,
    input  logic             use_reg_i,
    output logic [XLEN-1:0]  dest_o,
    output logic [XLEN-1:0]  link_o
);
    localparam int EXTW = XLEN - DISPW - 2;

    logic [XLEN-1:0] byte_off;

    generate
        if (EXTW > 0) begin : g_ext
            assign byte_off = {{EXTW{disp_i[DISPW-1]}}, disp_i, 2'b00};
        end else begin : g_trunc
            assign byte_off = XLEN'({disp_i, 2'b00});
        end
    endgenerate

    assign dest_o = use_reg_i ? reg_tgt_i : (pc_i + byte_off);
    assign link_o = pc_i + XLEN'(8);
endmodule

// File: rtl/dbt_unit.sv
module dbt_unit
    import dbt_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int DISPW    = 26,
    parameter int RIDXW    = 5,
    parameter int LINK_REG = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [2:0]       kind_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [DISPW-1:0] disp_i,
    input  logic [XLEN-1:0]  reg_tgt_i,
    input  logic             flag_i,
    input  logic [XLEN-1:0]  epc_i,
    input  logic [XLEN-1:0]  esr_i,
    output logic             slot_pending_o,
    output logic [XLEN-1:0]  target_o,
    output logic             redirect_o,
    output logic [XLEN-1:0]  redirect_pc_o,
    output logic             link_we_o,
    output logic [RIDXW-1:0] link_idx_o,
    output logic [XLEN-1:0]  link_val_o,
    output logic             sr_we_o,
    output logic [XLEN-1:0]  sr_val_o,
    output logic             illegal_o
);
    slot_state_e state_q, state_d;
    xfer_kind_e  kind;
    logic        taken, is_ctrl, links, use_reg, is_rfe;
    logic [XLEN-1:0] dest, link_nxt;

    assign kind = xfer_kind_e'(kind_i);

    dbt_decode u_decode (
        .kind_i    (kind),
        .flag_i    (flag_i),
        .taken_o   (taken),
        .is_ctrl_o (is_ctrl),
        .links_o   (links),
        .use_reg_o (use_reg),
        .is_rfe_o  (is_rfe)
    );

    dbt_target #(.XLEN(XLEN), .DISPW(DISPW)) u_target (
        .pc_i      (pc_i),
        .disp_i    (disp_i),
        .reg_tgt_i (reg_tgt_i),
        .use_reg_i (use_reg),
        .dest_o    (dest),
        .link_o    (link_nxt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (valid_i && taken) state_d = ST_SLOT;
            ST_SLOT: if (valid_i)          state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_o      <= '0;
            redirect_o    <= 1'b0;
            redirect_pc_o <= '0;
            link_we_o     <= 1'b0;
            link_val_o    <= '0;
            sr_we_o       <= 1'b0;
            sr_val_o      <= '0;
            illegal_o     <= 1'b0;
        end else begin
            redirect_o <= 1'b0;
            link_we_o  <= 1'b0;
            sr_we_o    <= 1'b0;
            illegal_o  <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (valid_i) begin
                    if (is_rfe) begin
                        redirect_o    <= 1'b1;
                        redirect_pc_o <= epc_i;
                        sr_we_o       <= 1'b1;
                        sr_val_o      <= esr_i;
                    end else if (taken) begin
                        target_o <= dest;
                        if (links) begin
                            link_we_o  <= 1'b1;
                            link_val_o <= link_nxt;
                        end
                    end
                end
                ST_SLOT: if (valid_i) begin
                    redirect_o    <= 1'b1;
                    redirect_pc_o <= target_o;
                    illegal_o     <= is_ctrl;
                end
                default: ;
            endcase
        end
    end

    assign slot_pending_o = (state_q == ST_SLOT);
    assign link_idx_o     = RIDXW'(LINK_REG);

    AST_SLOT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        slot_pending_o && !valid_i |=> slot_pending_o && $stable(target_o) && !redirect_o); // R6
    AST_SLOT_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
        slot_pending_o && valid_i |=> redirect_o && !slot_pending_o && redirect_pc_o == $past(target_o)); // R6
    AST_LINK_SKIPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> link_val_o == $past(pc_i) + XLEN'(8)); // R5
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> redirect_o && !link_we_o && !sr_we_o && !slot_pending_o); // R8
    AST_RESTORE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we_o |-> redirect_o && redirect_pc_o == $past(epc_i) && sr_val_o == $past(esr_i)); // R7
    AST_IDLE_WHEN_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_pending_o && !valid_i |=> !slot_pending_o && !redirect_o && !link_we_o); // R9
endmodule

// File: tb/dbt_unit_tb_top.sv
`timescale 1ns/1ps
module dbt_unit_tb_top;
    localparam int XLEN = 32;

    typedef struct {
        bit              redir;
        logic [XLEN-1:0] rpc;
        bit              slot;
        logic [XLEN-1:0] tgt;
        bit              lwe;
        logic [XLEN-1:0] lval;
        bit              swe;
        logic [XLEN-1:0] sval;
        bit              ill;
        string           tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid_i = 1'b0;
    logic [2:0] kind_i = '0;
    logic [XLEN-1:0] pc_i = '0, reg_tgt_i = '0, epc_i = '0, esr_i = '0;
    logic [25:0] disp_i = '0;
    logic flag_i = 1'b0;
    logic slot_pending_o, redirect_o, link_we_o, sr_we_o, illegal_o;
    logic [XLEN-1:0] target_o, redirect_pc_o, link_val_o, sr_val_o;
    logic [4:0] link_idx_o;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];
    bit   m_armed = 1'b0;
    logic [XLEN-1:0] m_tgt = '0;
    bit   mon_on = 1'b0;

    always #2.5 clk = ~clk;

    dbt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i),
        .pc_i(pc_i), .disp_i(disp_i), .reg_tgt_i(reg_tgt_i), .flag_i(flag_i),
        .epc_i(epc_i), .esr_i(esr_i), .slot_pending_o(slot_pending_o),
        .target_o(target_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_val_o(link_val_o),
        .sr_we_o(sr_we_o), .sr_val_o(sr_val_o), .illegal_o(illegal_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic issue(input bit v, input logic [2:0] k, input logic [XLEN-1:0] pc,
                         input logic [25:0] d, input logic [XLEN-1:0] rt,
                         input bit f, input string tag);
        exp_t e;
        bit tk;
        logic [XLEN-1:0] dst;
        @(negedge clk);
        valid_i = v; kind_i = k; pc_i = pc; disp_i = d; reg_tgt_i = rt; flag_i = f;
        e = '{redir:0, rpc:'0, slot:0, tgt:'0, lwe:0, lval:'0, swe:0, sval:'0, ill:0, tag:tag};
        tk  = (k inside {3'd1, 3'd2, 3'd3, 3'd4}) || (k == 3'd5 && f) || (k == 3'd6 && !f);
        dst = (k == 3'd3 || k == 3'd4) ? rt : pc + {{4{d[25]}}, d, 2'b00};
        if (v) begin
            if (m_armed) begin
                e.redir = 1; e.rpc = m_tgt; e.ill = (k != 3'd0); m_armed = 0;
            end else if (k == 3'd7) begin
                e.redir = 1; e.rpc = epc_i; e.swe = 1; e.sval = esr_i;
            end else if (tk) begin
                m_armed = 1; m_tgt = dst;
                if (k == 3'd2 || k == 3'd4) begin e.lwe = 1; e.lval = pc + 32'd8; end
            end
        end
        e.slot = m_armed; e.tgt = m_tgt;
        q.push_back(e);
    endtask

    // monitor: compares design outputs just after each active edge
    initial begin
        forever begin
            @(posedge clk); #1;
            if (mon_on && q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(redirect_o == e.redir, e.tag, "redirect", {31'b0, redirect_o}, {31'b0, e.redir});
                if (e.redir) check(redirect_pc_o == e.rpc, e.tag, "redirect_pc", redirect_pc_o, e.rpc);
                check(slot_pending_o == e.slot, e.tag, "slot", {31'b0, slot_pending_o}, {31'b0, e.slot});
                if (e.slot) check(target_o == e.tgt, e.tag, "target", target_o, e.tgt);
                check(link_we_o == e.lwe, e.tag, "link_we", {31'b0, link_we_o}, {31'b0, e.lwe});
                if (e.lwe) begin
                    check(link_val_o == e.lval, e.tag, "link_val", link_val_o, e.lval);
                    check(link_idx_o == 5'd9, e.tag, "link_idx", {27'b0, link_idx_o}, 32'd9);
                end
                check(sr_we_o == e.swe, e.tag, "sr_we", {31'b0, sr_we_o}, {31'b0, e.swe});
                if (e.swe) check(sr_val_o == e.sval, e.tag, "sr_val", sr_val_o, e.sval);
                check(illegal_o == e.ill, e.tag, "illegal", {31'b0, illegal_o}, {31'b0, e.ill});
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(!slot_pending_o && !redirect_o && !link_we_o && !sr_we_o && !illegal_o,
              "R1", "strobes", {27'b0, slot_pending_o, redirect_o, link_we_o, sr_we_o, illegal_o}, '0);
        check(target_o == '0, "R1", "target", target_o, '0);
        @(negedge clk); rst_n = 1'b1; mon_on = 1'b1;

        // R2 forward jump then delay slot
        issue(1, 3'd1, 32'h100, 26'd3, '0, 0, "R2");
        issue(1, 3'd0, 32'h104, '0, '0, 0, "R6");
        // R2 negative displacement, R6 idle gaps in slot
        issue(1, 3'd1, 32'h200, 26'h3FFFFFE, '0, 0, "R2");
        issue(0, 3'd1, 32'h0, '0, '0, 0, "R6");
        issue(0, 3'd0, 32'h0, '0, '0, 0, "R6");
        issue(1, 3'd0, 32'h204, '0, '0, 0, "R6");
        // R3 flag polarities
        issue(1, 3'd5, 32'h300, 26'd16, '0, 1, "R3");
        issue(1, 3'd0, 32'h304, '0, '0, 0, "R3");
        issue(1, 3'd5, 32'h308, 26'd16, '0, 0, "R3");
        issue(1, 3'd6, 32'h30C, 26'd4, '0, 1, "R3");
        issue(1, 3'd6, 32'h310, 26'd4, '0, 0, "R3");
        issue(1, 3'd0, 32'h314, '0, '0, 0, "R3");
        // R4 register target, R5 link
        issue(1, 3'd3, 32'h400, 26'd99, 32'hDEAD_BEE0, 0, "R4");
        issue(1, 3'd0, 32'h404, '0, '0, 0, "R4");
        issue(1, 3'd4, 32'h500, '0, 32'h1234_5678, 0, "R5");
        issue(1, 3'd0, 32'h504, '0, '0, 0, "R5");
        issue(1, 3'd2, 32'hFFFF_FFFC, 26'd1, '0, 0, "R5");
        issue(1, 3'd0, 32'h0, '0, '0, 0, "R2");
        // R7 return from exception
        epc_i = 32'h0000_2000; esr_i = 32'h0000_8001;
        issue(1, 3'd7, 32'h600, '0, '0, 0, "R7");
        // R8 transfers inside the slot
        issue(1, 3'd1, 32'h700, 26'd8, '0, 0, "R8");
        issue(1, 3'd2, 32'h704, 26'd8, '0, 0, "R8");
        issue(1, 3'd0, 32'h708, '0, '0, 0, "R8");
        issue(1, 3'd3, 32'h800, '0, 32'h900, 0, "R8");
        issue(1, 3'd7, 32'h804, '0, '0, 0, "R8");
        issue(1, 3'd5, 32'h808, 26'd2, '0, 0, "R8");
        // R9 nothing issued / NONE
        issue(0, 3'd2, 32'hA00, 26'd1, '0, 1, "R9");
        issue(1, 3'd0, 32'hA04, 26'd1, '0, 1, "R9");
        issue(0, 3'd7, 32'hA08, '0, '0, 0, "R9");
        repeat (3) @(posedge clk);
        #2;
        check(q.size() == 0, "R9", "drain", q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule